// File: doc/BRIEF.md
# Trigonometric Functional-Link Linearizer

This block turns one signed sensor sample into a linearised displacement estimate. The sample goes through a single-layer functional-link network. The block builds a basis vector from the sample: the sample itself, then the sine and cosine of m·π·v for every harmonic m from 1 up to the configured count (25 by default), giving 51 terms. It multiplies each term by a stored weight and adds the weighted terms into one output word. All data words are 18-bit signed fixed point with 14 fraction bits, so 1.0 is the code 16384.

A single multiply-accumulate handles one basis term per clock. The sine and cosine values come from a quarter-wave lookup table with symmetry folding. A sample is accepted with a valid/ready handshake, and the result appears a fixed number of cycles later as a one-cycle valid pulse. Weights are written one at a time through an address/data/write-enable port, normally while the block is idle. Weights are trained elsewhere and loaded through this port.

Top module: `flc_compensator`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, out_data is 0 and every weight is 0, so a sample processed before any weight write gives the result 0.
- R2: Basis term k (which uses weight address k) is the sample v for k = 0, sin(m·π·v) for k = 2m−1 and cos(m·π·v) for k = 2m, with m from 1 to 25. Writing 16384 (1.0) to one address and 0 to all the others makes the output equal that single term.
- R3: For harmonic m the phase is the low 15 bits of m·v, where v is the 18-bit signed code and the phase is in units of 2π/32768. Cosine adds 8192 to the phase modulo 32768. The low 5 phase bits are dropped. The term is then round(16384·sin(2π·phase/32768)), with ties rounded away from zero.
- R4: Each product is floor((term·weight + 8192) / 16384), clamped to the range −131072 to 131071.
- R5: Products are added in order from term 0 to term 50 into a running sum that starts at 0. After every addition the sum is clamped to the range −131072 to 131071, so it never wraps.
- R6: out_valid is high for exactly one cycle, 52 rising clock edges after the edge that accepted the sample. out_data holds the result until the next result replaces it.
- R7: in_ready is low from the accepting edge until the cycle in which out_valid is high. Samples offered while in_ready is low are neither taken nor answered.
- R8: A weight write takes effect only when in_ready is high and the address is below 51. A write while busy, or to address 51 or above, changes no weight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample offered |
| in_sample | input | 18 | Signed Q3.14 sensor sample |
| in_ready | output | 1 | High while idle and able to take a sample |
| w_we | input | 1 | Weight write strobe |
| w_addr | input | 6 | Weight index (basis term number) |
| w_data | input | 18 | Signed Q3.14 weight value |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 18 | Signed Q3.14 compensated result |

## Verification
Each internal fault shows up at the ports on the very next result, 52 cycles after the sample is accepted. A wrong term counter or phase step moves the error into one particular term, and loading a single non-zero weight at that address exposes it directly. A wrong folding quadrant gives a sine or cosine with the wrong sign or the wrong mirror index. Weak clamping makes a large sum wrap to the opposite sign instead of pinning at the limit. A write that slips past the busy or address guard changes a later result computed with known weights. A timing error in the sequencer moves the out_valid pulse away from edge 52.

// File: rtl/flc_pkg.sv
`timescale 1ns/1ps
package flc_pkg;
  localparam int DATA_W  = 18;
  localparam int FRAC_W  = 14;
  localparam int PHASE_W = FRAC_W + 1;

  typedef logic signed [DATA_W-1:0] sample_t;
  typedef logic signed [2*DATA_W:0] wide_t;

  localparam sample_t SAT_MAX  = {1'b0, {(DATA_W-1){1'b1}}};
  localparam sample_t SAT_MIN  = {1'b1, {(DATA_W-1){1'b0}}};
  localparam wide_t   WIDE_MAX = wide_t'(SAT_MAX);
  localparam wide_t   WIDE_MIN = wide_t'(SAT_MIN);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} seq_state_t;

  function automatic sample_t clamp_wide(input wide_t x);
    if (x > WIDE_MAX)      return SAT_MAX;
    else if (x < WIDE_MIN) return SAT_MIN;
    else                   return sample_t'(x);
  endfunction

  // fixed-point product, round half up, clamped to the data range
  function automatic sample_t mul_round(input sample_t a, input sample_t b);
    wide_t p;
    wide_t r;
    p = wide_t'(a) * wide_t'(b);
    r = (p + wide_t'(1 << (FRAC_W - 1))) >>> FRAC_W;
    return clamp_wide(r);
  endfunction

  function automatic sample_t sat_add(input sample_t a, input sample_t b);
    return clamp_wide(wide_t'(a) + wide_t'(b));
  endfunction

  // one entry of the quarter-wave table: sin(pi/2 * i/n) in Q.FRAC_W
  function automatic sample_t quarter_sine(input int i, input int n);
    real ang;
    ang = 1.5707963267948966 * real'(i) / real'(n);
    return sample_t'($rtoi(real'(1 << FRAC_W) * $sin(ang) + 0.5));
  endfunction
endpackage

// File: rtl/flc_sine_lut.sv
`timescale 1ns/1ps
module flc_sine_lut
  import flc_pkg::*;
#(
  parameter int PH_W     = PHASE_W,
  parameter int ROM_BITS = 8
) (
  input  logic [PH_W-1:0] phase,
  output sample_t         value
);
  localparam int QN = 1 << ROM_BITS;

  sample_t rom [QN+1];

  for (genvar i = 0; i <= QN; i++) begin : g_rom
    assign rom[i] = quarter_sine(i, QN);
  end

  logic [1:0]          quad;
  logic [ROM_BITS-1:0] idx;
  logic [ROM_BITS:0]   addr;
  sample_t             mag;
  logic                unused_phase_lsb;

  assign quad = phase[PH_W-1 -: 2];
  assign idx  = phase[PH_W-3 -: ROM_BITS];
  assign unused_phase_lsb = ^phase[PH_W-3-ROM_BITS:0];

  // odd quadrants read the table mirrored, upper half negates
  assign addr  = quad[0] ? ((ROM_BITS+1)'(QN) - {1'b0, idx}) : {1'b0, idx};
  assign mag   = rom[addr];
  assign value = quad[1] ? -mag : mag;
endmodule

// File: rtl/flc_weight_bank.sv
`timescale 1ns/1ps
module flc_weight_bank
  import flc_pkg::*;
#(
  parameter int DEPTH = 51,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  sample_t       wr_data,
  input  logic [AW-1:0] rd_addr,
  output sample_t       rd_data
);
  sample_t mem [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               mem[k] <= '0;
      else if (wr_en && wr_addr == AW'(k))      mem[k] <= wr_data;
    end
  end

  assign rd_data = (rd_addr < AW'(DEPTH)) ? mem[rd_addr] : '0;
endmodule

// File: rtl/flc_term_sequencer.sv
`timescale 1ns/1ps
module flc_term_sequencer
  import flc_pkg::*;
#(
  parameter int TERMS = 51,
  parameter int TW    = 6,
  parameter int PH_W  = PHASE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [PH_W-1:0] step,
  output logic            ready,
  output logic            start,
  output logic            run,
  output logic            finish,
  output logic [TW-1:0]   term_idx,
  output logic [PH_W-1:0] term_phase
);
  localparam logic [PH_W-1:0] QUARTER = PH_W'(1) << (PH_W - 2);

  seq_state_t      state;
  logic [PH_W-1:0] ph;

  assign ready  = (state == S_IDLE);
  assign start  = ready && in_valid;
  assign run    = (state == S_RUN);
  assign finish = (state == S_FIN);

  // odd terms are sines at the harmonic phase, even terms the cosines
  assign term_phase = term_idx[0] ? ph : ph + QUARTER;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      term_idx <= '0;
      ph       <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          state    <= S_RUN;
          term_idx <= '0;
          ph       <= '0;
        end
        S_RUN: begin
          term_idx <= term_idx + 1'b1;
          if (!term_idx[0]) ph <= ph + step;
          if (term_idx == TW'(TERMS - 1)) state <= S_FIN;
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flc_compensator.sv
`timescale 1ns/1ps
module flc_compensator
  import flc_pkg::*;
#(
  parameter int HARMONICS = 25,
  parameter int ROM_BITS  = 8,
  parameter int ADDR_W    = $clog2(2 * HARMONICS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_sample,
  output logic              in_ready,
  input  logic              w_we,
  input  logic [ADDR_W-1:0] w_addr,
  input  logic [DATA_W-1:0] w_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int TERMS = 2 * HARMONICS + 1;

  sample_t              sample_q;
  sample_t              acc;
  sample_t              lut_val;
  sample_t              w_rd;
  sample_t              term;
  sample_t              prod;
  sample_t              acc_next;
  logic                 seq_start;
  logic                 seq_run;
  logic                 seq_finish;
  logic                 wr_accept;
  logic [ADDR_W-1:0]    term_idx;
  logic [PHASE_W-1:0]   term_phase;

  assign wr_accept = w_we && in_ready;

  flc_term_sequencer #(.TERMS(TERMS), .TW(ADDR_W), .PH_W(PHASE_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .step       (sample_q[PHASE_W-1:0]),
    .ready      (in_ready),
    .start      (seq_start),
    .run        (seq_run),
    .finish     (seq_finish),
    .term_idx   (term_idx),
    .term_phase (term_phase)
  );

  flc_sine_lut #(.PH_W(PHASE_W), .ROM_BITS(ROM_BITS)) u_lut (
    .phase (term_phase),
    .value (lut_val)
  );

  flc_weight_bank #(.DEPTH(TERMS), .AW(ADDR_W)) u_wts (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_accept),
    .wr_addr (w_addr),
    .wr_data (sample_t'(w_data)),
    .rd_addr (term_idx),
    .rd_data (w_rd)
  );

  assign term     = (term_idx == '0) ? sample_q : lut_val;
  assign prod     = mul_round(term, w_rd);
  assign acc_next = sat_add(acc, prod);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_q  <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= seq_finish;
      if (seq_start) begin
        sample_q <= sample_t'(in_sample);
        acc      <= '0;
      end else if (seq_run) begin
        acc <= acc_next;
      end
      if (seq_finish) out_data <= acc;
    end
  end
endmodule

// File: rtl/flc_checker.sv
`timescale 1ns/1ps
module flc_checker
  import flc_pkg::*;
#(
  parameter int TERMS  = 51,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              run,
  input logic [ADDR_W-1:0] term_idx,
  input sample_t           lut_val,
  input logic              wr_accept
);
  localparam int LAT = TERMS + 1;

  logic       trk;
  logic [7:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trk <= 1'b0;
      cnt <= '0;
    end else if (in_valid && in_ready) begin
      trk <= 1'b1;
      cnt <= '0;
    end else if (trk) begin
      cnt <= cnt + 1'b1;
      if (out_valid) trk <= 1'b0;
    end
  end

  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (trk && cnt == 8'(LAT)));
  a_r6_on_time: assert property (@(posedge clk) disable iff (!rst_n)
    (trk && cnt == 8'(LAT)) |-> out_valid);
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  a_r7_ready_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);
  a_r2_first_term: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (run && term_idx == '0));
  a_r3_lut_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (lut_val <= sample_t'(1 << FRAC_W) && lut_val >= -sample_t'(1 << FRAC_W)));
  a_r8_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> !wr_accept);
endmodule

bind flc_compensator flc_checker #(.TERMS(TERMS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .run       (seq_run),
  .term_idx  (term_idx),
  .lut_val   (lut_val),
  .wr_accept (wr_accept)
);

// File: tb/flc_compensator_test.sv
`timescale 1ns/1ps
module flc_compensator_test;
  localparam int NT = 51;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [17:0] in_sample = '0;
  logic        in_ready;
  logic        w_we = 1'b0;
  logic [5:0]  w_addr = '0;
  logic [17:0] w_data = '0;
  logic        out_valid;
  logic [17:0] out_data;

  int     n_run = 0;
  int     n_fail = 0;
  longint wm [NT];

  always #5 clk = ~clk;

  flc_compensator uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .in_ready(in_ready), .w_we(w_we), .w_addr(w_addr), .w_data(w_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint clamp18(input longint x);
    if (x > 131071) return 131071;
    if (x < -131072) return -131072;
    return x;
  endfunction

  function automatic longint basis(input int t, input longint v);
    longint ph;
    longint m;
    real s;
    if (t == 0) return v;
    m  = longint'((t + 1) / 2);
    ph = (m * v) & 32767;
    if (t % 2 == 0) ph = (ph + 8192) & 32767;
    ph = ph & ~longint'(31);
    s  = $sin(6.283185307179586 * real'(ph) / 32768.0);
    if (s >= 0.0) return longint'($rtoi(s * 16384.0 + 0.5));
    return -longint'($rtoi(-s * 16384.0 + 0.5));
  endfunction

  function automatic longint model(input longint v);
    longint acc = 0;
    for (int t = 0; t < NT; t++) begin
      longint p;
      p   = clamp18((basis(t, v) * wm[t] + 8192) >>> 14);
      acc = clamp18(acc + p);
    end
    return acc;
  endfunction

  task automatic put_w(input int a, input longint d);
    @(negedge clk);
    w_we = 1'b1; w_addr = 6'(a); w_data = 18'(d);
    @(negedge clk);
    w_we = 1'b0;
    if (a < NT) wm[a] = d;
  endtask

  task automatic onehot(input int t);
    for (int k = 0; k < NT; k++) if (wm[k] != 0) put_w(k, 0);
    put_w(t, 16384);
  endtask

  task automatic run_chk(input longint v, input string req, input bit poke_busy);
    longint exp;
    exp = model(v);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_sample = 18'(v);
    @(posedge clk); #1;
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R7 ready drops", longint'(in_ready), 0);
    for (int i = 0; i < 51; i++) begin
      @(posedge clk); #1;
      if (poke_busy && i == 10) begin
        w_we = 1'b1; w_addr = 6'd0; w_data = 18'h1FFFF;
        in_valid = 1'b1; in_sample = 18'h12345;
      end
      if (poke_busy && i == 16) begin
        w_we = 1'b0; in_valid = 1'b0;
      end
    end
    chk(out_valid == 1'b0, "R6 not early", longint'(out_valid), 0);
    @(posedge clk); #1;
    chk(out_valid == 1'b1, "R6 pulse at edge 52", longint'(out_valid), 1);
    chk($signed(out_data) == exp, req, longint'($signed(out_data)), exp);
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int hold;
    void'($urandom(32'd2024));
    for (int k = 0; k < NT; k++) wm[k] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == 1'b0, "R1 out_valid reset", longint'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready reset", longint'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_data == '0, "R1 out_data reset", longint'(out_data), 0);
    run_chk(60000, "R1 zero weights", 1'b0);

    // single-term probes of the basis ordering and lookup
    onehot(0);  run_chk(-70000, "R2 term0 sample", 1'b0);
    onehot(1);  run_chk(8192, "R2 R3 sin pi/2", 1'b0);
    onehot(2);  run_chk(8192, "R2 R3 cos pi/2", 1'b0);
    onehot(3);  run_chk(4096, "R2 R3 sin 2x", 1'b0);
    onehot(4);  run_chk(-5000, "R2 R3 cos 2x neg", 1'b0);
    onehot(25); run_chk(12345, "R2 R3 sin 13x", 1'b0);
    onehot(26); run_chk(-131072, "R2 R3 cos 13x minimum", 1'b0);
    onehot(49); run_chk(77777, "R2 R3 sin 25x", 1'b0);
    onehot(50); run_chk(3000, "R2 R3 cos 25x", 1'b0);

    // R6 hold after the pulse
    @(posedge clk); #1;
    chk(out_valid == 1'b0, "R6 single cycle", longint'(out_valid), 0);
    hold = int'($signed(out_data));
    repeat (3) @(posedge clk);
    #1;
    chk(int'($signed(out_data)) == hold, "R6 out_data holds", longint'($signed(out_data)), longint'(hold));

    // random weights, random samples
    for (int k = 0; k < NT; k++) put_w(k, longint'($signed(18'($urandom()))) >>> 3);
    for (int n = 0; n < 20; n++) run_chk(longint'($signed(18'($urandom()))), "R4 R5 random", 1'b0);

    // out-of-range addresses change nothing
    put_w(51, 131071); put_w(63, -131072);
    run_chk(20000, "R8 address above 50 ignored", 1'b0);

    // writes and samples during busy are ignored
    run_chk(-33333, "R8 busy write ignored", 1'b1);
    repeat (60) begin
      @(posedge clk); #1;
      if (out_valid) chk(1'b0, "R7 busy sample not answered", 1, 0);
    end
    chk(in_ready == 1'b1, "R7 idle after ignored sample", longint'(in_ready), 1);
    run_chk(-33333, "R8 weight0 unchanged", 1'b0);

    // saturation, both directions and order-dependent clamping
    for (int k = 0; k < NT; k++) put_w(k, 131071);
    run_chk(16384, "R5 positive saturation", 1'b0);
    for (int k = 0; k < NT; k++) put_w(k, -131072);
    run_chk(100000, "R5 negative saturation", 1'b0);
    put_w(0, 131071);
    for (int k = 1; k < NT; k++) put_w(k, (k % 2 == 0) ? -40000 : 30000);
    run_chk(131071, "R5 clamp then descend", 1'b0);
    run_chk(-131072, "R4 R5 clamp from minimum", 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule